// File: doc/BRIEF.md
# Prioritized Interrupt Factor Flag

This block is a single interrupt source slice for a peripheral. It keeps three small pieces of state: a factor flag, an enable bit and a priority level. Two completion pulses set the flag. One comes from a one-shot transfer and the other from an automatic transfer. Software can read and write all three fields through a narrow register port. The flag is cleared only by writing a one to it.

The slice compares its programmed priority against the CPU's current interrupt mask level. While the flag is set, the enable is on and the priority is strictly above the mask, it drives exactly one request line. That line is the one whose number equals the priority. Priority 0 never requests. The request is a level that follows its conditions directly. Vectoring, arbitration between several sources and the CPU itself sit outside this block.

Top module: `irq_factor_slice`

## Requirements
- R1: After reset the priority reads 0, the enable reads 0, the flag reads 0 and no request line is active.
- R2: Writing with select 2'b00 stores cfg_wdata as the priority, and reading with select 2'b00 returns it.
- R3: Writing with select 2'b01 stores cfg_wdata bit 0 as the enable, and reading with select 2'b01 returns it in bit 0 with the upper bits zero.
- R4: A one-cycle pulse on either evt_oneshot or evt_auto sets the flag on the next clock edge, whatever the enable and priority values are. The flag reads in bit 0 under select 2'b10.
- R5: A write with select 2'b10 and cfg_wdata bit 0 = 1 clears the flag. The same write with bit 0 = 0 leaves the flag unchanged.
- R6: If an event pulse and a clearing write fall in the same cycle, the flag ends up set.
- R7: A request is raised only when the flag is 1, the enable is 1 and the priority is strictly greater than cpu_mask. Priority 0 never raises one.
- R8: Priority level k (1 to 3) drives irq_req bit k-1, and at most one request bit is ever active.
- R9: The request is level-sensitive. It drops in the same cycle that cpu_mask reaches the priority, and right after the edge that clears the flag or the enable.
- R10: Select 2'b11 reads as zero, and writes to it change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Field select: 00 priority, 01 enable, 10 flag, 11 unused |
| cfg_wdata | input | LVL_W | Write data |
| cfg_rdata | output | LVL_W | Read data of the selected field (combinational) |
| evt_oneshot | input | 1 | One-shot transfer completion pulse |
| evt_auto | input | 1 | Automatic transfer completion pulse |
| cpu_mask | input | LVL_W | CPU's current interrupt mask level |
| irq_req | output | 2**LVL_W-1 | Request lines; bit k-1 carries level k |

## Verification
The bench builds the slice with the default LVL_W of 2, which gives four levels and three request lines. With that size a table can cover every interesting pairing of priority against mask. The table includes the equal-level cases where no request may appear. It also alternates the two event inputs and toggles the enable.

Directed tests cover the remaining corners. They check that the flag latches while disabled and that a write of zero leaves it untouched. They check that set wins over clear in the same cycle. They also check that the request drops in the same cycle the mask catches up with the priority.

// File: rtl/irq_factor_slice.sv
module irq_factor_slice #(
  parameter int LVL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [LVL_W-1:0]          cfg_wdata,
  output logic [LVL_W-1:0]          cfg_rdata,
  input  logic                      evt_oneshot,
  input  logic                      evt_auto,
  input  logic [LVL_W-1:0]          cpu_mask,
  output logic [(1<<LVL_W)-2:0]     irq_req
);

  localparam int NUM_LINES = (1 << LVL_W) - 1;
  localparam logic [1:0] SEL_PRIO = 2'b00;
  localparam logic [1:0] SEL_EN   = 2'b01;
  localparam logic [1:0] SEL_FLAG = 2'b10;

  logic [LVL_W-1:0] prio_q;
  logic             en_q;
  logic             flag_q;

  wire evt_any   = evt_oneshot | evt_auto;
  wire flag_clr  = cfg_we && (cfg_sel == SEL_FLAG) && cfg_wdata[0];
  wire req_live  = flag_q && en_q && (prio_q > cpu_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_PRIO) prio_q <= cfg_wdata;
      if (cfg_sel == SEL_EN)   en_q   <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (evt_any)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    case (cfg_sel)
      SEL_PRIO: cfg_rdata = prio_q;
      SEL_EN:   cfg_rdata = {{(LVL_W-1){1'b0}}, en_q};
      SEL_FLAG: cfg_rdata = {{(LVL_W-1){1'b0}}, flag_q};
      default:  cfg_rdata = '0;
    endcase
  end

  for (genvar k = 1; k <= NUM_LINES; k++) begin : g_line
    assign irq_req[k-1] = req_live && (prio_q == LVL_W'(k));
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_req)); // R8
  AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n) (irq_req != '0) |-> (prio_q > cpu_mask)); // R7
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> (irq_req == '0)); // R7
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) evt_any |=> flag_q); // R4 R6
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !evt_any) |=> !flag_q); // R5
  AST_W0_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (!flag_clr && !evt_any) |=> $stable(flag_q)); // R5

endmodule

// File: tb/tb_irq_factor_slice.sv
module tb_irq_factor_slice;
  localparam int LVL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic [LVL_W-1:0] cfg_wdata = '0;
  logic [LVL_W-1:0] cfg_rdata;
  logic evt_oneshot = 1'b0;
  logic evt_auto = 1'b0;
  logic [LVL_W-1:0] cpu_mask = '0;
  logic [2:0] irq_req;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  irq_factor_slice #(.LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_oneshot(evt_oneshot),
    .evt_auto(evt_auto), .cpu_mask(cpu_mask), .irq_req(irq_req)
  );

  // {prio[1:0], en, mask[1:0], expected irq_req[2:0]}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b11_1_00_100, 8'b11_1_10_100, 8'b11_1_11_000, 8'b10_1_01_010,
    8'b10_1_10_000, 8'b01_1_00_001, 8'b01_1_01_000, 8'b00_1_00_000,
    8'b11_0_00_000, 8'b10_0_00_000, 8'b01_1_11_000, 8'b10_1_00_010
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [LVL_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse(input bit use_auto);
    @(negedge clk);
    if (use_auto) evt_auto = 1'b1; else evt_oneshot = 1'b1;
    @(negedge clk);
    evt_auto = 1'b0; evt_oneshot = 1'b0;
  endtask

  function automatic int rd(input logic [1:0] sel);
    cfg_sel = sel;
    return 0;
  endfunction

  task automatic read(input logic [1:0] sel, output int v);
    cfg_sel = sel;
    #1 v = int'(cfg_rdata);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    read(2'b00, v); check("R1 prio", v, 0);
    read(2'b01, v); check("R1 en", v, 0);
    read(2'b10, v); check("R1 flag", v, 0);
    check("R1 irq", int'(irq_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'b00, 2'd2); read(2'b00, v); check("R2 prio readback", v, 2);
    wr(2'b01, 2'b11); read(2'b01, v); check("R3 en readback", v, 1);

    for (int i = 0; i < NV; i++) begin
      wr(2'b10, 2'b01);
      wr(2'b00, VEC[i][7:6]);
      wr(2'b01, {1'b0, VEC[i][5]});
      cpu_mask = VEC[i][4:3];
      pulse(i % 2 == 1);
      #1 check($sformatf("R7 R8 R4 vector %0d", i), int'(irq_req), int'(VEC[i][2:0]));
    end

    cpu_mask = 2'd0;
    wr(2'b10, 2'b01); wr(2'b01, 2'b00); wr(2'b00, 2'd0);
    pulse(1'b0);
    read(2'b10, v); check("R4 flag set while disabled", v, 1);
    check("R4 no req while disabled", int'(irq_req), 0);
    wr(2'b10, 2'b10);
    read(2'b10, v); check("R5 write 0 keeps flag", v, 1);
    wr(2'b10, 2'b01);
    read(2'b10, v); check("R5 write 1 clears flag", v, 0);

    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b10; cfg_wdata = 2'b01; evt_auto = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; evt_auto = 1'b0;
    read(2'b10, v); check("R6 set beats clear", v, 1);

    wr(2'b00, 2'd2); wr(2'b01, 2'b01);
    #1 check("R9 req active", int'(irq_req), 2);
    @(negedge clk); cpu_mask = 2'd2;
    #1 check("R9 drop on mask reach", int'(irq_req), 0);
    cpu_mask = 2'd1;
    #1 check("R9 restore on mask lower", int'(irq_req), 2);
    wr(2'b01, 2'b00);
    #1 check("R9 drop on enable clear", int'(irq_req), 0);
    wr(2'b01, 2'b01);
    wr(2'b10, 2'b01);
    #1 check("R9 drop on flag clear", int'(irq_req), 0);

    wr(2'b11, 2'b11);
    read(2'b11, v); check("R10 unused reads zero", v, 0);
    read(2'b00, v); check("R10 prio untouched", v, 2);
    read(2'b01, v); check("R10 en untouched", v, 1);
    read(2'b10, v); check("R10 flag untouched", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule